// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multi-Cycle Datapath

This block is the control unit of a multi-cycle processor datapath. It steps through a small control store of encoded microinstructions. Each microinstruction holds a few narrow fields: ALU operation, operand selects, a write-back selector, a memory action, a PC-update action and a two-bit sequencing code. A set of field decoders expands those fields into the individual control points that the datapath consumes.

The sequencing code picks the next micro-address. It can restart at the fetch step, dispatch on the instruction opcode through a computed dispatch table, or advance to the following address. Every instruction begins with a common fetch step and a common decode step. After these, the opcode sampled at the end of decode selects a routine of one or two steps. Each routine returns to fetch.

The datapath, register file and memories are not part of this block. Only the opcode comes in, and only the control points go out.

Top module: `ucode_ctrl`

## Requirements
- R1: Reset is synchronous and active high. The clock edge at which reset is high makes the fetch step the current step. The fetch step stays current while reset is held and for the first cycle after reset is released, including when reset arrives in the middle of a routine.
- R2: Fetch step controls:
  - alu_op=00 (add), alu_a_sel=0 (PC), alu_b_sel=001 (constant 4).
  - mem_re=1, mem_addr_alu=0 (address from PC), ir_we=1.
  - pc_we=1, pc_next_sel=00 (ALU result).
  - The step after fetch is always decode.
- R3: Decode step controls: alu_op=00, alu_a_sel=0, alu_b_sel=011 (shifted sign-extended immediate), tgt_we=1. The opcode is sampled only at the clock edge that ends decode. Opcode values in any other cycle have no effect on the step sequence.
- R4: Dispatch sends each opcode to its routine:
  - 0x00 goes to register-register.
  - 0x23 goes to load.
  - 0x2B goes to store.
  - 0x04 goes to branch-equal.
  - 0x02 goes to jump.
  - 0x0D goes to OR-immediate.
  - Every other opcode returns to fetch directly after decode.
- R5: Load runs two steps. Both steps drive alu_op=00, alu_a_sel=1 (rs) and alu_b_sel=010 (sign-extended immediate). The second step also drives mem_re=1, mem_addr_alu=1, rf_we=1, rf_wdata_mem=1 and rf_dst_rd=0.
- R6: Store runs two steps with the same ALU controls as load. The second step also drives mem_we=1 and mem_addr_alu=1.
- R7: Register-register runs two steps with alu_op=10 (function code), alu_a_sel=1 and alu_b_sel=000 (rt). The second step also drives rf_we=1, rf_dst_rd=1 and rf_wdata_mem=0.
- R8: Branch-equal runs one step: alu_op=01 (subtract), alu_a_sel=1, alu_b_sel=000, pc_we_ifz=1, pc_next_sel=01 (Target), pc_we=0.
- R9: Jump runs one step: pc_we=1 and pc_next_sel=10 (jump address).
- R10: OR-immediate runs two steps with alu_op=11 (OR), alu_a_sel=1 and alu_b_sel=100 (zero-extended immediate). The second step also drives rf_we=1, rf_dst_rd=0 and rf_wdata_mem=0.
- R11: The cycle after each routine's last step is a fetch step. In every step, any control not named for that step is 0.
- R12: Mutually exclusive actions never coincide:
  - mem_re and mem_we are never both high.
  - pc_we and pc_we_ifz are never both high.
  - ir_we implies a memory read addressed by PC.
  - rf_wdata_mem implies rf_we and mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the current instruction |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function code, 11 OR |
| alu_a_sel | output | 1 | First ALU operand: 0 PC, 1 rs |
| alu_b_sel | output | 3 | Second ALU operand: 000 rt, 001 four, 010 sign-ext, 011 sign-ext shifted, 100 zero-ext |
| rf_we | output | 1 | Register file write enable |
| rf_wdata_mem | output | 1 | Register write data: 0 ALU result, 1 memory data |
| rf_dst_rd | output | 1 | Destination register: 0 rt, 1 rd |
| tgt_we | output | 1 | Target register write from ALU |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| mem_addr_alu | output | 1 | Memory address: 0 PC, 1 ALU output |
| ir_we | output | 1 | Instruction register write |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_ifz | output | 1 | PC write when the ALU zero flag is set |
| pc_next_sel | output | 2 | PC source: 00 ALU, 01 Target, 10 jump address |

## Verification
A wrong micro-address or a corrupted field shows up at the ports in the same cycle as a wrong control word. Almost every step has a distinct word. The exception is the first step of load and store, which share one word, so a mix-up between those two routines only appears one cycle later, when the memory action differs. A wrong dispatch entry shows in the first cycle after decode. A broken return path shows in the cycle after a routine ends, as a missing fetch. The sweep drives all 64 opcodes so that every dispatch entry is observed, and it changes the opcode during execute steps to show that it is ignored there.

// File: rtl/ucode_pkg.sv
`timescale 1ns/1ps
package ucode_pkg;

  localparam int OPC_W  = 6;
  localparam int UA_W   = 4;
  localparam int ALU_W  = 2;
  localparam int SRCB_W = 3;
  localparam int PCS_W  = 2;

  // ALU operation codes (driven straight to the datapath)
  localparam logic [ALU_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [ALU_W-1:0] ALU_SUB  = 2'b01;
  localparam logic [ALU_W-1:0] ALU_FUNC = 2'b10;
  localparam logic [ALU_W-1:0] ALU_OR   = 2'b11;

  // Second operand select codes
  localparam logic [SRCB_W-1:0] SB_RT   = 3'b000;
  localparam logic [SRCB_W-1:0] SB_FOUR = 3'b001;
  localparam logic [SRCB_W-1:0] SB_SEXT = 3'b010;
  localparam logic [SRCB_W-1:0] SB_SHFT = 3'b011;
  localparam logic [SRCB_W-1:0] SB_ZEXT = 3'b100;

  // PC source codes
  localparam logic [PCS_W-1:0] PCS_ALU = 2'b00;
  localparam logic [PCS_W-1:0] PCS_TGT = 2'b01;
  localparam logic [PCS_W-1:0] PCS_JMP = 2'b10;

  // Opcodes recognised by dispatch
  localparam logic [OPC_W-1:0] OP_RR   = 6'h00;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OP_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OP_LOAD = 6'h23;
  localparam logic [OPC_W-1:0] OP_STOR = 6'h2B;

  // Micro-addresses of each step
  localparam logic [UA_W-1:0] UA_FETCH = UA_W'(0);
  localparam logic [UA_W-1:0] UA_DECO  = UA_W'(1);
  localparam logic [UA_W-1:0] UA_LDA   = UA_W'(2);
  localparam logic [UA_W-1:0] UA_LDB   = UA_W'(3);
  localparam logic [UA_W-1:0] UA_STA   = UA_W'(4);
  localparam logic [UA_W-1:0] UA_STB   = UA_W'(5);
  localparam logic [UA_W-1:0] UA_RRA   = UA_W'(6);
  localparam logic [UA_W-1:0] UA_RRB   = UA_W'(7);
  localparam logic [UA_W-1:0] UA_BEQ   = UA_W'(8);
  localparam logic [UA_W-1:0] UA_JMP   = UA_W'(9);
  localparam logic [UA_W-1:0] UA_ORA   = UA_W'(10);
  localparam logic [UA_W-1:0] UA_ORB   = UA_W'(11);

  // Sequencing code: the values are the next-address selector encoding
  typedef enum logic [1:0] {SQ_FETCH = 2'b00, SQ_DISP = 2'b01, SQ_NEXT = 2'b10} seq_e;
  // Single write-back selector: one source, one destination at a time
  typedef enum logic [2:0] {WB_NONE, WB_TGT, WB_RD_ALU, WB_RT_ALU, WB_RT_MEM} wb_e;
  // Memory action
  typedef enum logic [1:0] {MA_NONE, MA_IFETCH, MA_LOAD, MA_STORE} mem_e;
  // PC update action
  typedef enum logic [1:0] {PW_NONE, PW_ALU, PW_TGT_IFZ, PW_JUMP} pcw_e;

  typedef struct packed {
    logic [ALU_W-1:0]  alu;
    logic              src_a;
    logic [SRCB_W-1:0] src_b;
    wb_e               wb;
    mem_e              mem;
    pcw_e              pcw;
    seq_e              seq;
  } uword_t;

  typedef struct packed {
    logic [ALU_W-1:0]  alu_op;
    logic              a_sel;
    logic [SRCB_W-1:0] b_sel;
    logic              rf_we;
    logic              rf_mem;
    logic              rf_rd;
    logic              tgt_we;
    logic              mem_re;
    logic              mem_we;
    logic              maddr_alu;
    logic              ir_we;
    logic              pc_we;
    logic              pc_ifz;
    logic [PCS_W-1:0]  pc_sel;
  } ctrl_t;

  function automatic uword_t mk(input logic [ALU_W-1:0] alu, input logic sa,
                                input logic [SRCB_W-1:0] sb, input wb_e wb,
                                input mem_e mem, input pcw_e pcw, input seq_e sq);
    uword_t w;
    w.alu = alu; w.src_a = sa; w.src_b = sb;
    w.wb = wb; w.mem = mem; w.pcw = pcw; w.seq = sq;
    return w;
  endfunction

  // Control store contents
  function automatic uword_t ucode_word(input logic [UA_W-1:0] a);
    case (a)
      UA_FETCH: return mk(ALU_ADD,  1'b0, SB_FOUR, WB_NONE,   MA_IFETCH, PW_ALU,     SQ_NEXT);
      UA_DECO:  return mk(ALU_ADD,  1'b0, SB_SHFT, WB_TGT,    MA_NONE,   PW_NONE,    SQ_DISP);
      UA_LDA:   return mk(ALU_ADD,  1'b1, SB_SEXT, WB_NONE,   MA_NONE,   PW_NONE,    SQ_NEXT);
      UA_LDB:   return mk(ALU_ADD,  1'b1, SB_SEXT, WB_RT_MEM, MA_LOAD,   PW_NONE,    SQ_FETCH);
      UA_STA:   return mk(ALU_ADD,  1'b1, SB_SEXT, WB_NONE,   MA_NONE,   PW_NONE,    SQ_NEXT);
      UA_STB:   return mk(ALU_ADD,  1'b1, SB_SEXT, WB_NONE,   MA_STORE,  PW_NONE,    SQ_FETCH);
      UA_RRA:   return mk(ALU_FUNC, 1'b1, SB_RT,   WB_NONE,   MA_NONE,   PW_NONE,    SQ_NEXT);
      UA_RRB:   return mk(ALU_FUNC, 1'b1, SB_RT,   WB_RD_ALU, MA_NONE,   PW_NONE,    SQ_FETCH);
      UA_BEQ:   return mk(ALU_SUB,  1'b1, SB_RT,   WB_NONE,   MA_NONE,   PW_TGT_IFZ, SQ_FETCH);
      UA_JMP:   return mk(ALU_ADD,  1'b0, SB_RT,   WB_NONE,   MA_NONE,   PW_JUMP,    SQ_FETCH);
      UA_ORA:   return mk(ALU_OR,   1'b1, SB_ZEXT, WB_NONE,   MA_NONE,   PW_NONE,    SQ_NEXT);
      UA_ORB:   return mk(ALU_OR,   1'b1, SB_ZEXT, WB_RT_ALU, MA_NONE,   PW_NONE,    SQ_FETCH);
      default:  return mk(ALU_ADD,  1'b0, SB_RT,   WB_NONE,   MA_NONE,   PW_NONE,    SQ_FETCH);
    endcase
  endfunction

  // Dispatch table: unknown opcodes go back to fetch
  function automatic logic [UA_W-1:0] dispatch_addr(input logic [OPC_W-1:0] op);
    case (op)
      OP_RR:   return UA_RRA;
      OP_LOAD: return UA_LDA;
      OP_STOR: return UA_STA;
      OP_BEQ:  return UA_BEQ;
      OP_JMP:  return UA_JMP;
      OP_ORI:  return UA_ORA;
      default: return UA_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/ucode_rom.sv
`timescale 1ns/1ps
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  // Synchronous read: the control store maps onto a block RAM
  always_ff @(posedge clk) begin
    word <= ucode_word(addr);
  end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import ucode_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int OW = OPC_W
) (
  input  logic          rst,
  input  logic [AW-1:0] upc,
  input  seq_e          seq,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (rst) begin
      nxt = '0;
    end else begin
      case (seq)
        SQ_DISP: nxt = dispatch_addr(opcode);
        SQ_NEXT: nxt = upc + AW'(1);
        default: nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/ufield_decode.sv
`timescale 1ns/1ps
module ufield_decode
  import ucode_pkg::*;
(
  input  uword_t uw,
  output ctrl_t  c
);
  always_comb begin
    c        = '0;
    c.alu_op = uw.alu;
    c.a_sel  = uw.src_a;
    c.b_sel  = uw.src_b;

    case (uw.wb)
      WB_TGT:    c.tgt_we = 1'b1;
      WB_RD_ALU: begin c.rf_we = 1'b1; c.rf_rd = 1'b1; end
      WB_RT_ALU: c.rf_we = 1'b1;
      WB_RT_MEM: begin c.rf_we = 1'b1; c.rf_mem = 1'b1; end
      default:   ;
    endcase

    case (uw.mem)
      MA_IFETCH: begin c.mem_re = 1'b1; c.ir_we = 1'b1; end
      MA_LOAD:   begin c.mem_re = 1'b1; c.maddr_alu = 1'b1; end
      MA_STORE:  begin c.mem_we = 1'b1; c.maddr_alu = 1'b1; end
      default:   ;
    endcase

    case (uw.pcw)
      PW_ALU:     begin c.pc_we  = 1'b1; c.pc_sel = PCS_ALU; end
      PW_TGT_IFZ: begin c.pc_ifz = 1'b1; c.pc_sel = PCS_TGT; end
      PW_JUMP:    begin c.pc_we  = 1'b1; c.pc_sel = PCS_JMP; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/ucode_ctrl.sv
`timescale 1ns/1ps
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int OW = OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OW-1:0]     opcode,
  output logic [ALU_W-1:0]  alu_op,
  output logic              alu_a_sel,
  output logic [SRCB_W-1:0] alu_b_sel,
  output logic              rf_we,
  output logic              rf_wdata_mem,
  output logic              rf_dst_rd,
  output logic              tgt_we,
  output logic              mem_re,
  output logic              mem_we,
  output logic              mem_addr_alu,
  output logic              ir_we,
  output logic              pc_we,
  output logic              pc_we_ifz,
  output logic [PCS_W-1:0]  pc_next_sel
);
  logic [AW-1:0] upc;
  logic [AW-1:0] nxt;
  uword_t        uw;
  ctrl_t         c;

  useq_next #(.AW(AW), .OW(OW)) u_seq (
    .rst    (rst),
    .upc    (upc),
    .seq    (uw.seq),
    .opcode (opcode),
    .nxt    (nxt)
  );

  // micro-PC and control word load from the same next address
  always_ff @(posedge clk) begin
    upc <= nxt;
  end

  ucode_rom #(.AW(AW)) u_rom (
    .clk  (clk),
    .addr (nxt),
    .word (uw)
  );

  ufield_decode u_dec (
    .uw (uw),
    .c  (c)
  );

  assign alu_op       = c.alu_op;
  assign alu_a_sel    = c.a_sel;
  assign alu_b_sel    = c.b_sel;
  assign rf_we        = c.rf_we;
  assign rf_wdata_mem = c.rf_mem;
  assign rf_dst_rd    = c.rf_rd;
  assign tgt_we       = c.tgt_we;
  assign mem_re       = c.mem_re;
  assign mem_we       = c.mem_we;
  assign mem_addr_alu = c.maddr_alu;
  assign ir_we        = c.ir_we;
  assign pc_we        = c.pc_we;
  assign pc_we_ifz    = c.pc_ifz;
  assign pc_next_sel  = c.pc_sel;
endmodule

// File: rtl/ucode_ctrl_chk.sv
`timescale 1ns/1ps
module ucode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rf_we,
  input logic       rf_wdata_mem,
  input logic       tgt_we,
  input logic       mem_re,
  input logic       mem_we,
  input logic       mem_addr_alu,
  input logic       ir_we,
  input logic       pc_we,
  input logic       pc_we_ifz,
  input logic [1:0] pc_next_sel
);
  a_r12_mem_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  a_r12_pc_excl: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && pc_we_ifz));

  a_r12_ir_from_pc: assert property (@(posedge clk) disable iff (rst)
    ir_we |-> (mem_re && !mem_addr_alu));

  a_r12_wb_mem: assert property (@(posedge clk) disable iff (rst)
    rf_wdata_mem |-> (rf_we && mem_re));

  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (ir_we && pc_we));

  a_r3_decode_follows: assert property (@(posedge clk) disable iff (rst)
    ir_we |=> (tgt_we && !ir_we));

  a_r11_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (rf_we || mem_we || pc_we_ifz || (pc_we && pc_next_sel == 2'b10)) |=> ir_we);
endmodule

bind ucode_ctrl ucode_ctrl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .rf_we        (rf_we),
  .rf_wdata_mem (rf_wdata_mem),
  .tgt_we       (tgt_we),
  .mem_re       (mem_re),
  .mem_we       (mem_we),
  .mem_addr_alu (mem_addr_alu),
  .ir_we        (ir_we),
  .pc_we        (pc_we),
  .pc_we_ifz    (pc_we_ifz),
  .pc_next_sel  (pc_next_sel)
);

// File: tb/test_ucode_ctrl.sv
`timescale 1ns/1ps
module test_ucode_ctrl;

  localparam int S_FETCH = 0, S_DEC = 1, S_ADDR = 2, S_LDM = 3, S_STM = 4,
                 S_RRE = 5, S_RRW = 6, S_BEQ = 7, S_JMP = 8, S_ORE = 9, S_ORW = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [1:0] alu_op;
  logic       alu_a_sel;
  logic [2:0] alu_b_sel;
  logic       rf_we, rf_wdata_mem, rf_dst_rd, tgt_we;
  logic       mem_re, mem_we, mem_addr_alu, ir_we, pc_we, pc_we_ifz;
  logic [1:0] pc_next_sel;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  ucode_ctrl i_ucode_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_we(rf_we), .rf_wdata_mem(rf_wdata_mem), .rf_dst_rd(rf_dst_rd),
    .tgt_we(tgt_we), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr_alu(mem_addr_alu), .ir_we(ir_we), .pc_we(pc_we),
    .pc_we_ifz(pc_we_ifz), .pc_next_sel(pc_next_sel)
  );

  // Expected control word per step, from the requirements; unnamed controls are 0 (R11)
  function automatic logic [17:0] exp_vec(input int s);
    logic [1:0] alu = 2'b00; logic a = 0; logic [2:0] b = 3'b000;
    logic rfwe = 0, rfm = 0, rfrd = 0, tg = 0, mre = 0, mwe = 0, mal = 0;
    logic ir = 0, pw = 0, pz = 0; logic [1:0] ps = 2'b00;
    case (s)
      S_FETCH: begin b = 3'b001; mre = 1; ir = 1; pw = 1; end
      S_DEC:   begin b = 3'b011; tg = 1; end
      S_ADDR:  begin a = 1; b = 3'b010; end
      S_LDM:   begin a = 1; b = 3'b010; mre = 1; mal = 1; rfwe = 1; rfm = 1; end
      S_STM:   begin a = 1; b = 3'b010; mwe = 1; mal = 1; end
      S_RRE:   begin alu = 2'b10; a = 1; end
      S_RRW:   begin alu = 2'b10; a = 1; rfwe = 1; rfrd = 1; end
      S_BEQ:   begin alu = 2'b01; a = 1; pz = 1; ps = 2'b01; end
      S_JMP:   begin pw = 1; ps = 2'b10; end
      S_ORE:   begin alu = 2'b11; a = 1; b = 3'b100; end
      S_ORW:   begin alu = 2'b11; a = 1; b = 3'b100; rfwe = 1; end
      default: ;
    endcase
    return {alu, a, b, rfwe, rfm, rfrd, tg, mre, mwe, mal, ir, pw, pz, ps};
  endfunction

  task automatic check(input string tag, input int s);
    logic [17:0] got, exp;
    got = {alu_op, alu_a_sel, alu_b_sel, rf_we, rf_wdata_mem, rf_dst_rd, tgt_we,
           mem_re, mem_we, mem_addr_alu, ir_we, pc_we, pc_we_ifz, pc_next_sel};
    exp = exp_vec(s);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%02h step=%0d got=%b expected=%b", tag, opcode, s, got, exp);
    end
  endtask

  // Called at a negedge inside a fetch cycle; ends at the negedge of the next fetch cycle
  task automatic run_op(input logic [5:0] op, input bit scramble);
    int    st[5];
    string tg[5];
    int    n;
    opcode = op;
    st[0] = S_DEC; tg[0] = "R3";
    n = 1;
    case (op)
      6'h00: begin st[1] = S_RRE; tg[1] = "R7 via R4"; st[2] = S_RRW; tg[2] = "R7"; n = 3; end
      6'h23: begin st[1] = S_ADDR; tg[1] = "R5 via R4"; st[2] = S_LDM; tg[2] = "R5"; n = 3; end
      6'h2B: begin st[1] = S_ADDR; tg[1] = "R6 via R4"; st[2] = S_STM; tg[2] = "R6"; n = 3; end
      6'h04: begin st[1] = S_BEQ; tg[1] = "R8 via R4"; n = 2; end
      6'h02: begin st[1] = S_JMP; tg[1] = "R9 via R4"; n = 2; end
      6'h0D: begin st[1] = S_ORE; tg[1] = "R10 via R4"; st[2] = S_ORW; tg[2] = "R10"; n = 3; end
      default: ;
    endcase
    st[n] = S_FETCH;
    tg[n] = (n == 1) ? "R4 unknown opcode to fetch" : "R11 return to fetch";
    n++;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tg[i], st[i]);
      // R3: opcode changes after the decode edge must not alter the routine
      if (scramble && i >= 1) opcode = op ^ 6'h2A ^ 6'(i);
    end
    opcode = op;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fetch held in reset", S_FETCH);
    rst = 1'b0;
    // first cycle after release is this fetch; R2 fetch is followed by decode
    run_op(6'h23, 0);
    check("R2 fetch step", S_FETCH);

    // exhaustive opcode sweep (R4 and all routines)
    for (int o = 0; o < 64; o++) run_op(6'(o), 0);

    // R3: opcode ignored outside decode
    run_op(6'h00, 1);
    run_op(6'h23, 1);
    run_op(6'h2B, 1);
    run_op(6'h0D, 1);
    run_op(6'h04, 1);

    // R1: reset in the middle of a load routine
    opcode = 6'h23;
    @(negedge clk); check("R3 decode before reset", S_DEC);
    @(negedge clk); check("R5 address step before reset", S_ADDR);
    rst = 1'b1;
    @(negedge clk); check("R1 mid-routine reset to fetch", S_FETCH);
    rst = 1'b0;
    run_op(6'h02, 0);
    run_op(6'h2B, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule